// File: doc/BRIEF.md
# Paged Window Memory Decoder

This block sits on the peripheral side of an 8-bit expansion bus that carries eight address lines, a read/write line, a 1 MHz enable and two active-low page strobes. One strobe marks an access to a shared I/O page and the other marks an access to a 256-byte data window. The block holds an 8-bit page number in a write-only register at the top byte of the I/O page. It maps every window access onto a 16-bit address of an external RAM, formed from the page number and the eight bus address lines, so the 256-byte window can reach any byte of a 64 KB store.

The block drives the RAM chip-select, output-enable and write-enable, and returns read data to the bus under an output-enable flag. It can also decode a small user register range in the I/O page, with a select and a one-cycle write strobe for a neighbouring device. Every other I/O offset is left alone so that other devices can share the page. The 1 MHz enable is sampled in a faster system clock, and the block treats its falling edge as the point where write data is taken.

Top module: `paged_window_dec`

## Requirements
- R1: The RAM chip-select `ram_cs_n` is low exactly when `win_sel_n` is low and `io_sel_n` is high.
- R2: A write (`bus_rnw` = 0) with `io_sel_n` low at offset 0xFF loads `bus_wdata` into the page register on the clock edge at which `bus_e` is first sampled low after being high. From the next cycle the new page appears on `ram_addr[15:8]`.
- R3: The page register is write-only: a read of I/O offset 0xFF never sets `bus_drive`.
- R4: Reset clears the page register to 0x00, so `ram_addr[15:8]` is 0x00 after reset.
- R5: `ram_addr` equals {page register, `bus_addr`} at all times.
- R6: `page_user` is high exactly when the page register is 0x80 or above.
- R7: I/O offsets other than 0xFF and the user range are not claimed: no bus drive, no RAM select, and writes to them leave the page register unchanged.
- R8: With `io_sel_n` low and `bus_addr` in 0x50..0x5F, `usr_sel` is high, a read with `bus_e` high drives `usr_rdata` to the bus, and a write gives a one-cycle `usr_wstb` on the falling edge of `bus_e`.
- R9: `bus_drive` is high only for a read (`bus_rnw` = 1) with `bus_e` high of a window or user-range address. `bus_rdata` then carries `ram_rdata` for the window or `usr_rdata` for the user range.
- R10: `ram_oe_n` is low only for a window read with `bus_e` high, and `ram_we_n` is low only for a window write with `bus_e` high.
- R11: With both strobes high, `ram_cs_n`, `ram_oe_n` and `ram_we_n` stay high and `usr_sel` stays low.
- R12: With both strobes low, the access is treated as an I/O-page access and the window is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus enable |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | 1 MHz bus enable, synchronous to clk |
| bus_rnw | input | 1 | High for read, low for write |
| io_sel_n | input | 1 | Active-low I/O page strobe |
| win_sel_n | input | 1 | Active-low data window strobe |
| bus_addr | input | 8 | Offset within the selected page |
| bus_wdata | input | 8 | Write data from the bus |
| ram_rdata | input | 8 | Read data from external RAM |
| usr_rdata | input | 8 | Read data from the user register range |
| ram_addr | output | 16 | External RAM address {page, offset} |
| ram_cs_n | output | 1 | Active-low RAM chip-select |
| ram_oe_n | output | 1 | Active-low RAM output-enable |
| ram_we_n | output | 1 | Active-low RAM write-enable |
| bus_rdata | output | 8 | Read data back to the bus |
| bus_drive | output | 1 | Bus data output enable |
| page_user | output | 1 | Current page is in the user half |
| usr_sel | output | 1 | User range selected |
| usr_wstb | output | 1 | One-cycle user-range write strobe |

## Verification
Window reads and writes run at several page numbers on each side of 0x80, so an address-concatenation or page-flag error shows up as a wrong `ram_addr` or `page_user`. I/O-page writes go to 0xFF, to its neighbour 0xFE and to offsets at and just outside the edges of the user range. These tell the one register byte apart from nearby unclaimed offsets. A read of 0xFF, idle cycles and cycles with both strobes low separate correct non-response from stray drives or selects. Every stimulus is held across the rise and fall of `bus_e`, so the bench can also see when the page loads and when the user strobe fires.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PAGE = 2'd1,
    TGT_USER = 2'd2,
    TGT_WIN  = 2'd3
  } tgt_e;
endpackage

// File: rtl/pwd_edge.sv
module pwd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic e_in,
  output logic e_fall
);
  logic e_prev_q;
  logic e_prev_d;

  always_comb begin
    e_prev_d = e_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_prev_q <= 1'b0;
    else        e_prev_q <= e_prev_d;
  end

  assign e_fall = e_prev_q & ~e_in;
endmodule

// File: rtl/pwd_decode.sv
module pwd_decode
  import pwd_pkg::*;
#(
  parameter int          OFS_W   = 8,
  parameter logic [7:0]  REG_OFS = 8'hFF,
  parameter bit          USR_EN  = 1'b1,
  parameter logic [7:0]  USR_LO  = 8'h50,
  parameter logic [7:0]  USR_HI  = 8'h5F
) (
  input  logic             io_sel_n,
  input  logic             win_sel_n,
  input  logic [OFS_W-1:0] addr,
  output tgt_e             tgt
);
  logic in_usr;

  generate
    if (USR_EN) begin : g_usr
      assign in_usr = (addr >= OFS_W'(USR_LO)) && (addr <= OFS_W'(USR_HI));
    end else begin : g_nousr
      assign in_usr = 1'b0;
    end
  endgenerate

  always_comb begin
    tgt = TGT_NONE;
    if (!io_sel_n) begin
      if (addr == OFS_W'(REG_OFS)) tgt = TGT_PAGE;
      else if (in_usr)             tgt = TGT_USER;
    end else if (!win_sel_n) begin
      tgt = TGT_WIN;
    end
  end
endmodule

// File: rtl/pwd_page_reg.sv
module pwd_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [PAGE_W-1:0] din,
  output logic [PAGE_W-1:0] page
);
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_d = page;
    if (ld) page_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page <= '0;
    else        page <= page_d;
  end
endmodule

// File: rtl/paged_window_dec.sv
module paged_window_dec
  import pwd_pkg::*;
#(
  parameter int         OFS_W   = 8,
  parameter int         PAGE_W  = 8,
  parameter int         DATA_W  = 8,
  parameter logic [7:0] REG_OFS = 8'hFF,
  parameter bit         USR_EN  = 1'b1,
  parameter logic [7:0] USR_LO  = 8'h50,
  parameter logic [7:0] USR_HI  = 8'h5F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_e,
  input  logic                     bus_rnw,
  input  logic                     io_sel_n,
  input  logic                     win_sel_n,
  input  logic [OFS_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic [DATA_W-1:0]        ram_rdata,
  input  logic [DATA_W-1:0]        usr_rdata,
  output logic [PAGE_W+OFS_W-1:0]  ram_addr,
  output logic                     ram_cs_n,
  output logic                     ram_oe_n,
  output logic                     ram_we_n,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_drive,
  output logic                     page_user,
  output logic                     usr_sel,
  output logic                     usr_wstb
);
  localparam int RAM_AW = PAGE_W + OFS_W;

  tgt_e              tgt;
  logic              e_fall;
  logic              win_hit, usr_hit, pg_hit, page_ld;
  logic [PAGE_W-1:0] page_q;

  pwd_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .e_in   (bus_e),
    .e_fall (e_fall)
  );

  pwd_decode #(
    .OFS_W   (OFS_W),
    .REG_OFS (REG_OFS),
    .USR_EN  (USR_EN),
    .USR_LO  (USR_LO),
    .USR_HI  (USR_HI)
  ) u_dec (
    .io_sel_n  (io_sel_n),
    .win_sel_n (win_sel_n),
    .addr      (bus_addr),
    .tgt       (tgt)
  );

  assign win_hit = (tgt == TGT_WIN);
  assign usr_hit = (tgt == TGT_USER);
  assign pg_hit  = (tgt == TGT_PAGE);
  assign page_ld = pg_hit & ~bus_rnw & e_fall;

  pwd_page_reg #(.PAGE_W(PAGE_W)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (page_ld),
    .din   (bus_wdata[PAGE_W-1:0]),
    .page  (page_q)
  );

  assign ram_addr  = RAM_AW'({page_q, bus_addr});
  assign ram_cs_n  = ~win_hit;
  assign ram_oe_n  = ~(win_hit & bus_rnw & bus_e);
  assign ram_we_n  = ~(win_hit & ~bus_rnw & bus_e);
  assign bus_drive = bus_rnw & bus_e & (win_hit | usr_hit);
  assign page_user = page_q[PAGE_W-1];
  assign usr_sel   = usr_hit;
  assign usr_wstb  = usr_hit & ~bus_rnw & e_fall;

  always_comb begin
    bus_rdata = '0;
    unique case (tgt)
      TGT_WIN:  bus_rdata = ram_rdata;
      TGT_USER: bus_rdata = usr_rdata;
      default:  bus_rdata = '0;
    endcase
  end

  AST_PAGE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_sel_n && bus_addr == OFS_W'(REG_OFS)) |-> !bus_drive); // R3
  AST_PAGE_LOAD_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr[RAM_AW-1:OFS_W] != $past(ram_addr[RAM_AW-1:OFS_W]))
      |-> ($past(!io_sel_n) && $past(bus_addr) == OFS_W'(REG_OFS) && $past(!bus_rnw))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel_n && win_sel_n) |-> (ram_cs_n && ram_we_n && ram_oe_n && !usr_sel)); // R11
  AST_DRIVE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive |-> (bus_e && bus_rnw)); // R9
  AST_WE_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!win_sel_n && io_sel_n && bus_e)); // R10
  AST_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_sel_n && !win_sel_n) |-> ram_cs_n); // R12
  AST_USTB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    usr_wstb |=> !usr_wstb); // R8
endmodule

// File: tb/test_paged_window_dec.sv
module test_paged_window_dec;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_e = 1'b0, bus_rnw = 1'b1, io_sel_n = 1'b1, win_sel_n = 1'b1;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, ram_rdata = 8'h00, usr_rdata = 8'h00;
  logic [15:0] ram_addr;
  logic ram_cs_n, ram_oe_n, ram_we_n, bus_drive, page_user, usr_sel, usr_wstb;
  logic [7:0] bus_rdata;

  int n_chk = 0, n_err = 0;
  int m_page = 0;
  int m_eprev = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  paged_window_dec i_paged_window_dec (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rnw(bus_rnw),
    .io_sel_n(io_sel_n), .win_sel_n(win_sel_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ram_rdata(ram_rdata), .usr_rdata(usr_rdata),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .bus_rdata(bus_rdata), .bus_drive(bus_drive),
    .page_user(page_user), .usr_sel(usr_sel), .usr_wstb(usr_wstb)
  );

  // behavioural reference: page number and previous enable level
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_page = 0; m_eprev = 0;
    end else begin
      if (m_eprev == 1 && !bus_e && !io_sel_n && bus_addr == 8'hFF && !bus_rnw)
        m_page = int'(bus_wdata);
      m_eprev = bus_e ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit io, win, usr, rd, drv;
    int a;
    io  = !io_sel_n;
    win = !win_sel_n && !io;
    a   = int'(bus_addr);
    usr = io && a >= 8'h50 && a <= 8'h5F;
    rd  = bus_rnw;
    drv = rd && bus_e && (win || usr);
    chk(ram_addr == 16'(m_page * 256 + a), "R5 ram_addr", ram_addr, m_page * 256 + a);
    chk(ram_cs_n == !win, "R1 ram_cs_n", ram_cs_n, !win);
    chk(ram_oe_n == !(win && rd && bus_e), "R10 ram_oe_n", ram_oe_n, !(win && rd && bus_e));
    chk(ram_we_n == !(win && !rd && bus_e), "R10 ram_we_n", ram_we_n, !(win && !rd && bus_e));
    chk(bus_drive == drv, "R9 bus_drive", bus_drive, drv);
    if (drv)
      chk(bus_rdata == (win ? ram_rdata : usr_rdata), "R9 bus_rdata", bus_rdata,
          win ? ram_rdata : usr_rdata);
    chk(page_user == (m_page >= 128), "R6 page_user", page_user, m_page >= 128);
    chk(usr_sel == usr, "R8 usr_sel", usr_sel, usr);
    chk(usr_wstb == (usr && !rd && m_eprev == 1 && !bus_e), "R8 usr_wstb", usr_wstb,
        usr && !rd && m_eprev == 1 && !bus_e);
  endtask

  task automatic step(input bit e);
    @(negedge clk);
    bus_e = e;
    #1;
    compare();
  endtask

  task automatic bus_cycle(input bit io_n, input bit win_n, input logic [7:0] a,
                           input bit rnw, input logic [7:0] wd);
    @(negedge clk);
    io_sel_n = io_n; win_sel_n = win_n; bus_addr = a; bus_rnw = rnw; bus_wdata = wd;
    bus_e = 1'b0;
    #1; compare();
    step(1'b1); step(1'b1);
    step(1'b0); step(1'b0);
    @(negedge clk);
    io_sel_n = 1'b1; win_sel_n = 1'b1; bus_rnw = 1'b1;
    #1; compare();
  endtask

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(ram_addr[15:8] == 8'h00, "R4 reset page", ram_addr[15:8], 0);
    chk(ram_cs_n == 1'b1, "R4 reset cs", ram_cs_n, 1);
    rst_n = 1'b1;
    step(1'b0);
    chk(ram_addr[15:8] == 8'h00, "R4 page after release", ram_addr[15:8], 0);

    ram_rdata = 8'hA5; usr_rdata = 8'h3C;
    bus_cycle(1'b1, 1'b0, 8'h10, 1'b1, 8'h00);        // window read page 0
    bus_cycle(1'b0, 1'b1, 8'hFF, 1'b0, 8'h93);        // load page 0x93
    chk(ram_addr[15:8] == 8'h93, "R2 page loaded", ram_addr[15:8], 8'h93);
    chk(page_user == 1'b1, "R6 user half", page_user, 1);
    bus_cycle(1'b1, 1'b0, 8'h21, 1'b1, 8'h00);        // window read
    bus_cycle(1'b1, 1'b0, 8'hFE, 1'b0, 8'h77);        // window write
    // read of page register must not drive
    @(negedge clk);
    io_sel_n = 1'b0; bus_addr = 8'hFF; bus_rnw = 1'b1; bus_e = 1'b1;
    #1; compare();
    chk(bus_drive == 1'b0, "R3 no readback", bus_drive, 0);
    bus_cycle(1'b0, 1'b1, 8'hFE, 1'b0, 8'h11);        // unclaimed offset
    chk(ram_addr[15:8] == 8'h93, "R7 page kept after FE", ram_addr[15:8], 8'h93);
    bus_cycle(1'b0, 1'b1, 8'h4F, 1'b1, 8'h00);        // just below user range
    bus_cycle(1'b0, 1'b1, 8'h60, 1'b0, 8'h22);        // just above user range
    chk(ram_addr[15:8] == 8'h93, "R7 page kept after 60", ram_addr[15:8], 8'h93);
    bus_cycle(1'b0, 1'b1, 8'h50, 1'b1, 8'h00);        // user read low edge
    bus_cycle(1'b0, 1'b1, 8'h5F, 1'b0, 8'h44);        // user write high edge
    bus_cycle(1'b0, 1'b1, 8'hFF, 1'b0, 8'h7F);        // page 0x7F, reserved half
    chk(page_user == 1'b0, "R6 reserved half", page_user, 0);
    bus_cycle(1'b0, 1'b0, 8'h33, 1'b0, 8'h55);        // both strobes low
    chk(ram_cs_n == 1'b1, "R12 both low no window", ram_cs_n, 1);
    bus_cycle(1'b0, 1'b0, 8'hFF, 1'b0, 8'h80);        // both low, page write
    chk(ram_addr[15:8] == 8'h80, "R12 io wins page load", ram_addr[15:8], 8'h80);
    ram_rdata = 8'h5A;
    bus_cycle(1'b1, 1'b0, 8'h00, 1'b1, 8'h00);
    @(negedge clk);
    bus_e = 1'b1; bus_rnw = 1'b0;
    #1; compare();
    chk(ram_cs_n && ram_we_n && !usr_sel, "R11 idle quiet", {ram_cs_n, ram_we_n, usr_sel}, 3'b110);
    step(1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule